// File: doc/BRIEF.md
# Two-Bus Register Datapath

This block is the register and bus core of a small accumulator machine. It holds five working registers (accumulator, memory data, counter, status and instruction), one ALU staging register that feeds the ALU's left input, and a one-bit zero flag. Each clock cycle is controlled by one microinstruction word that arrives on plain control pins. The read select picks one of four registers as the ALU's right operand. The ALU code and carry-in choose the operation. The write select places either the external operand or the ALU result on the write bus. One enable per destination says which registers take the write-bus value.

Every bus value is formed combinationally from the register contents as they stood before the edge. All enabled destinations then load together on one rising clock edge. A microinstruction may therefore read a register and overwrite it in the same cycle, and it always sees the old value. The zero flag has its own enable and records whether the ALU result is zero, whichever source the write bus selected. The control pins carry no handshake: the sequencer that drives them presents a new microinstruction every cycle and never stalls, so back-pressure does not arise.

Top module: `two_bus_datapath`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all six registers and the zero flag to 0. Reset takes priority over every write enable.
- R2: The read bus feeds the ALU right operand. The 2-bit read select chooses the source as follows: 0 gives the accumulator, 1 the memory data register, 2 the counter register and 3 the status register.
- R3: The write bus carries ext_in when wr_sel is 0 and the ALU result when wr_sel is 1.
- R4: Each of the six registers loads the write-bus value at a rising edge only when its own enable is high. A register whose enable is low keeps its value.
- R5: The ALU left operand is the staging register and the right operand is the read bus. All results are truncated to W bits. The ALU codes are: 0 gives left+right+cin; 1 gives left-right-cin; 2 AND; 3 OR; 4 XOR; 5 gives the inverse of left; 6 gives the negation of left; 7 passes left unchanged.
- R6: With we_z high, the zero flag loads 1 if the ALU result is all zeros and 0 otherwise. With we_z low it holds.
- R7: Bus values are computed from the contents before the edge. When a register is both read and written in one cycle, the operand is its old value.
- R8: A loaded value appears on the observation outputs right after the edge that stores it, with no further delay.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_in | input | W | External operand for the write bus |
| rd_sel | input | 2 | Read-bus source select |
| wr_sel | input | 1 | Write-bus source: 0 external, 1 ALU |
| alu_op | input | 3 | ALU operation code |
| alu_cin | input | 1 | ALU carry/borrow in |
| we_ac | input | 1 | Accumulator write enable |
| we_md | input | 1 | Memory data register write enable |
| we_cr | input | 1 | Counter register write enable |
| we_sr | input | 1 | Status register write enable |
| we_b | input | 1 | ALU staging register write enable |
| we_ir | input | 1 | Instruction register write enable |
| we_z | input | 1 | Zero flag write enable |
| ac_o | output | W | Accumulator contents |
| md_o | output | W | Memory data register contents |
| cr_o | output | W | Counter register contents |
| sr_o | output | W | Status register contents |
| ir_o | output | W | Instruction register contents |
| z_o | output | 1 | Zero flag |

## Verification
All results of a microinstruction are due exactly one rising edge after it is presented: register loads, zero-flag updates and reset clearing. The bench changes inputs on the falling edge and applies each word for one cycle. It reads the outputs on the following falling edge, after the single storing edge and before the next one. The bench keeps a model of all seven state elements, including the hidden staging register. It advances this model once per cycle using only the pre-edge values, so every output is compared in the cycle where it is due.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int NUM_REGS = 6;
  localparam int SEL_W    = 2;
  localparam int OP_W     = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5,
    OP_NEG  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  // Register file slots; read-bus codes match slots 0..3.
  typedef enum int {
    SLOT_AC = 0,
    SLOT_MD = 1,
    SLOT_CR = 2,
    SLOT_SR = 3,
    SLOT_B  = 4,
    SLOT_IR = 5
  } reg_slot_e;
endpackage

// File: rtl/dp_en_reg.sv
module dp_en_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/dp_read_mux.sv
module dp_read_mux #(
  parameter int W     = 8,
  parameter int SRCS  = 4,
  localparam int SW   = $clog2(SRCS)
) (
  input  logic [W-1:0] src [SRCS],
  input  logic [SW-1:0] sel,
  output logic [W-1:0] bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < SRCS; i++) begin
      if (sel == SW'(i)) bus = src[i];
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    lhs,
  input  logic [W-1:0]    rhs,
  input  logic [OP_W-1:0] op,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            zero
);
  logic [W-1:0] cin_ext;
  assign cin_ext = {{(W-1){1'b0}}, cin};

  always_comb begin
    unique case (alu_op_e'(op))
      OP_ADD:  res = lhs + rhs + cin_ext;
      OP_SUB:  res = lhs - rhs - cin_ext;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_NOT:  res = ~lhs;
      OP_NEG:  res = -lhs;
      default: res = lhs;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/two_bus_datapath.sv
module two_bus_datapath
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ext_in,
  input  logic [1:0]   rd_sel,
  input  logic         wr_sel,
  input  logic [2:0]   alu_op,
  input  logic         alu_cin,
  input  logic         we_ac,
  input  logic         we_md,
  input  logic         we_cr,
  input  logic         we_sr,
  input  logic         we_b,
  input  logic         we_ir,
  input  logic         we_z,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] md_o,
  output logic [W-1:0] cr_o,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] ir_o,
  output logic         z_o
);
  localparam int RD_SRCS = 1 << SEL_W;

  logic [W-1:0]        regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] we_vec;
  logic [W-1:0]        rd_src [RD_SRCS];
  logic [W-1:0]        read_bus;
  logic [W-1:0]        alu_res;
  logic                alu_zero;
  logic [W-1:0]        write_bus;
  logic [W-1:0]        b_q;
  logic [0:0]          z_q;

  // Phase one: every bus from pre-edge state.
  always_comb begin
    we_vec          = '0;
    we_vec[SLOT_AC] = we_ac;
    we_vec[SLOT_MD] = we_md;
    we_vec[SLOT_CR] = we_cr;
    we_vec[SLOT_SR] = we_sr;
    we_vec[SLOT_B]  = we_b;
    we_vec[SLOT_IR] = we_ir;
  end

  genvar gi;
  generate
    for (gi = 0; gi < RD_SRCS; gi++) begin : g_rd_src
      assign rd_src[gi] = regs_q[gi];
    end
  endgenerate

  dp_read_mux #(.W(W), .SRCS(RD_SRCS)) u_rd_mux (
    .src (rd_src),
    .sel (rd_sel),
    .bus (read_bus)
  );

  assign b_q = regs_q[SLOT_B];

  dp_alu #(.W(W)) u_alu (
    .lhs  (b_q),
    .rhs  (read_bus),
    .op   (alu_op),
    .cin  (alu_cin),
    .res  (alu_res),
    .zero (alu_zero)
  );

  assign write_bus = wr_sel ? alu_res : ext_in;

  // Phase two: all enabled destinations commit on one edge.
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_regs
      dp_en_reg #(.W(W)) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (we_vec[gi]),
        .d   (write_bus),
        .q   (regs_q[gi])
      );
    end
  endgenerate

  dp_en_reg #(.W(1)) u_zflag (
    .clk (clk),
    .rst (rst),
    .en  (we_z),
    .d   (alu_zero),
    .q   (z_q)
  );

  assign ac_o = regs_q[SLOT_AC];
  assign md_o = regs_q[SLOT_MD];
  assign cr_o = regs_q[SLOT_CR];
  assign sr_o = regs_q[SLOT_SR];
  assign ir_o = regs_q[SLOT_IR];
  assign z_o  = z_q[0];
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ext_in,
  input logic [1:0]   rd_sel,
  input logic         wr_sel,
  input logic [2:0]   alu_op,
  input logic         alu_cin,
  input logic         we_ac,
  input logic         we_md,
  input logic         we_b,
  input logic         we_ir,
  input logic         we_z,
  input logic [W-1:0] ac_o,
  input logic [W-1:0] md_o,
  input logic [W-1:0] ir_o,
  input logic         z_o,
  input logic [W-1:0] b_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ac_o == '0 && md_o == '0 && ir_o == '0 && b_q == '0 && !z_o));

  p_hold_ac_r4: assert property (@(posedge clk) disable iff (rst)
    !we_ac |=> $stable(ac_o));

  p_hold_ir_r4: assert property (@(posedge clk) disable iff (rst)
    !we_ir |=> $stable(ir_o));

  p_ext_load_r3: assert property (@(posedge clk) disable iff (rst)
    (we_md && !wr_sel) |=> md_o == $past(ext_in));

  p_pass_left_r5: assert property (@(posedge clk) disable iff (rst)
    (we_ac && wr_sel && alu_op == 3'd7) |=> ac_o == $past(b_q));

  p_read_ac_r2: assert property (@(posedge clk) disable iff (rst)
    (we_ir && wr_sel && alu_op == 3'd3 && rd_sel == 2'd0)
      |=> ir_o == ($past(b_q) | $past(ac_o)));

  p_old_operand_r7: assert property (@(posedge clk) disable iff (rst)
    (we_b && wr_sel && alu_op == 3'd0 && !alu_cin && rd_sel == 2'd0)
      |=> b_q == $past(b_q) + $past(ac_o));

  p_zero_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !we_z |=> $stable(z_o));
endmodule

bind two_bus_datapath dp_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ext_in  (ext_in),
  .rd_sel  (rd_sel),
  .wr_sel  (wr_sel),
  .alu_op  (alu_op),
  .alu_cin (alu_cin),
  .we_ac   (we_ac),
  .we_md   (we_md),
  .we_b    (we_b),
  .we_ir   (we_ir),
  .we_z    (we_z),
  .ac_o    (ac_o),
  .md_o    (md_o),
  .ir_o    (ir_o),
  .z_o     (z_o),
  .b_q     (b_q)
);

// File: tb/two_bus_datapath_bench.sv
module two_bus_datapath_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst;
  logic [W-1:0] ext_in;
  logic [1:0]   rd_sel;
  logic         wr_sel;
  logic [2:0]   alu_op;
  logic         alu_cin;
  logic we_ac, we_md, we_cr, we_sr, we_b, we_ir, we_z;
  logic [W-1:0] ac_o, md_o, cr_o, sr_o, ir_o;
  logic         z_o;

  two_bus_datapath #(.W(W)) u_two_bus_datapath (
    .clk(clk), .rst(rst), .ext_in(ext_in), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .alu_op(alu_op), .alu_cin(alu_cin), .we_ac(we_ac), .we_md(we_md),
    .we_cr(we_cr), .we_sr(we_sr), .we_b(we_b), .we_ir(we_ir), .we_z(we_z),
    .ac_o(ac_o), .md_o(md_o), .cr_o(cr_o), .sr_o(sr_o), .ir_o(ir_o), .z_o(z_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model state.
  logic [W-1:0] m_ac, m_md, m_cr, m_sr, m_b, m_ir;
  logic         m_z;

  function automatic logic [W-1:0] ref_alu(input logic [W-1:0] l, input logic [W-1:0] r,
                                           input logic [2:0] op, input logic c);
    logic [W-1:0] ce;
    ce = {{(W-1){1'b0}}, c};
    case (op)
      3'd0: return l + r + ce;
      3'd1: return l - r - ce;
      3'd2: return l & r;
      3'd3: return l | r;
      3'd4: return l ^ r;
      3'd5: return ~l;
      3'd6: return -l;
      default: return l;
    endcase
  endfunction

  function automatic logic [W-1:0] ref_read(input logic [1:0] s);
    case (s)
      2'd0: return m_ac;
      2'd1: return m_md;
      2'd2: return m_cr;
      default: return m_sr;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " ac"}, ac_o, m_ac);
    chk({tag, " md"}, md_o, m_md);
    chk({tag, " cr"}, cr_o, m_cr);
    chk({tag, " sr"}, sr_o, m_sr);
    chk({tag, " ir"}, ir_o, m_ir);
    chk({tag, " z"},  {{(W-1){1'b0}}, z_o}, {{(W-1){1'b0}}, m_z});
  endtask

  // Applies one microinstruction at the falling edge; checks after the next rising edge.
  task automatic step(input logic [W-1:0] x, input logic [1:0] rs, input logic ws,
                      input logic [2:0] op, input logic c, input logic [6:0] we,
                      input string tag);
    logic [W-1:0] res, wb;
    ext_in = x; rd_sel = rs; wr_sel = ws; alu_op = op; alu_cin = c;
    {we_ac, we_md, we_cr, we_sr, we_b, we_ir, we_z} = we;
    res = ref_alu(m_b, ref_read(rs), op, c);
    wb  = ws ? res : x;
    if (rst) begin
      m_ac = '0; m_md = '0; m_cr = '0; m_sr = '0; m_b = '0; m_ir = '0; m_z = 1'b0;
    end else begin
      if (we[6]) m_ac = wb;
      if (we[5]) m_md = wb;
      if (we[4]) m_cr = wb;
      if (we[3]) m_sr = wb;
      if (we[2]) m_b  = wb;
      if (we[1]) m_ir = wb;
      if (we[0]) m_z  = (res == '0);
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd1234));
    rst = 1'b1;
    m_ac = 'x; m_md = 'x; m_cr = 'x; m_sr = 'x; m_b = 'x; m_ir = 'x; m_z = 1'bx;
    @(negedge clk);
    // R1: reset clears everything even with all enables set.
    step(8'hA5, 2'd0, 1'b0, 3'd0, 1'b0, 7'h7F, "R1 reset");
    rst = 1'b0;
    // R3/R4: load each register from ext_in one at a time; others hold.
    step(8'h11, 2'd0, 1'b0, 3'd0, 1'b0, 7'b1000000, "R3 R4 ac");
    step(8'h22, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0100000, "R3 R4 md");
    step(8'h33, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0010000, "R3 R4 cr");
    step(8'h44, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0001000, "R3 R4 sr");
    step(8'h00, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0000100, "R4 b");
    step(8'h55, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0000010, "R3 R4 ir");
    // R2: with B=0, ADD passes each read source to IR.
    for (int s = 0; s < 4; s++)
      step(8'h00, 2'(s), 1'b1, 3'd0, 1'b0, 7'b0000010, "R2 read select");
    // R5: every op with B loaded.
    step(8'h9C, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0000100, "R4 b load");
    for (int o = 0; o < 8; o++) begin
      step(8'h00, 2'd2, 1'b1, 3'(o), 1'b0, 7'b0000011, "R5 R6 op");
      step(8'h00, 2'd1, 1'b1, 3'(o), 1'b1, 7'b0000011, "R5 R6 op cin");
    end
    // R6: zero result sets Z; ext write bus does not hide it.
    step(8'h00, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0000100, "R6 b zero");
    step(8'h00, 2'd0, 1'b1, 3'd2, 1'b0, 7'b0000001, "R6 zero set");
    step(8'h77, 2'd0, 1'b0, 3'd5, 1'b0, 7'b0000001, "R6 nonzero clr");
    step(8'h00, 2'd0, 1'b1, 3'd6, 1'b0, 7'b0000000, "R6 hold");
    // R7: read and overwrite AC and B in the same cycle.
    step(8'h05, 2'd0, 1'b0, 3'd0, 1'b0, 7'b0000100, "R7 b");
    step(8'h00, 2'd0, 1'b1, 3'd0, 1'b0, 7'b1000100, "R7 same cycle");
    step(8'h00, 2'd0, 1'b1, 3'd7, 1'b0, 7'b0000010, "R7 b observed");
    // R8 + all: constrained random microinstructions.
    for (int n = 0; n < 400; n++) begin
      v = W'($urandom);
      step(v, 2'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
           7'($urandom), "R8 random");
    end
    // R1: mid-run reset.
    rst = 1'b1;
    step(8'hFF, 2'd3, 1'b1, 3'd5, 1'b1, 7'h7F, "R1 midrun reset");
    rst = 1'b0;
    step(8'h00, 2'd0, 1'b1, 3'd0, 1'b0, 7'h00, "R4 idle after reset");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule